// File: doc/BRIEF.md
# Audio Power-State Sequencer

This controller decides when the supply converters and the per-channel output stages of a stereo headphone driver are powered, and when the outputs may be treated as ready for audio. It takes the mode bits of the power-control register as a serial-bus front end has decoded them. These are a standby bit and one enable bit per channel. They arrive together with a one-cycle strobe that the front end raises at the eighth falling clock edge of that register's data byte. Both the wake-up interval and the power-down interval are timed from that strobe.

A synchronized over-temperature input overrides the software command. While it is high the sequencer powers down and shows a thermal flag. When it falls, the sequencer returns to the state that software last requested, and the flag clears without any register write. Interval lengths come from a clock-frequency parameter and two durations given in microseconds. The defaults are 12 ms for wake-up and 100 us for power-down.

Top module: `audio_pwr_seq`

## Requirements
- R1: After reset the sequencer is in standby: `convEn`, `chanEn`, `outReady` and `thermalFlag` are all 0.
- R2: A strobe with `cmdStandby` = 0 (0 means run, 1 means standby) and `overTemp` low, taken while in standby, sets `convEn` to 1 from the next clock edge.
- R3: `outReady` rises exactly WAKE cycles after the clock edge that took the waking strobe, where WAKE = CLK_HZ * WAKE_US / 1e6. It stays 0 before that.
- R4: `outReady` is 1 only in the fully powered state and never while `convEn` is 0.
- R5: A strobe with `cmdStandby` = 1 clears `outReady` and `chanEn` at the next edge. `convEn` stays 1 for SLEEP = CLK_HZ * SLEEP_US / 1e6 cycles and then drops to 0.
- R6: `chanEn[i]` (bit 0 left, bit 1 right) equals the enable bit i latched by the last strobe while the sequencer is waking or fully powered, and is 0 otherwise.
- R7: A further strobe during a wake-up that still requests run restarts the wake interval. A further standby strobe during a power-down restarts the power-down interval.
- R8: A run strobe during a power-down starts a wake-up at once: `convEn` never drops, and `outReady` rises WAKE cycles later.
- R9: While `overTemp` is high the sequencer powers down as in R5 and ignores run strobes. `outReady` is 0 from the edge after `overTemp` is seen high.
- R10: `thermalFlag` equals `overTemp` delayed by one clock and clears by itself.
- R11: When `overTemp` falls and the last command was run, a wake-up starts automatically. If the last command was standby, the sequencer stays in standby.
- R12: A strobe that repeats the current mode does not disturb the power state. It only reloads the channel enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStrobe | input | 1 | One-cycle pulse at the eighth falling clock edge of the power-control data byte |
| cmdStandby | input | 1 | Standby bit of that byte, valid with the strobe (1 = standby) |
| cmdEnable | input | NCH | Channel enable bits of that byte, valid with the strobe |
| overTemp | input | 1 | Synchronized over-temperature indication |
| convEn | output | 1 | Enables the positive buck and negative supply converters |
| chanEn | output | NCH | Per-channel output stage enable |
| outReady | output | 1 | Outputs operational after the de-pop interval |
| thermalFlag | output | 1 | Self-clearing thermal shutdown flag |

## Verification
The bench drives several patterns and compares every output against a behavioural countdown model on every cycle. The first pattern is a clean wake-up followed by a power-down. The second repeats strobes in the middle of a wake and in the middle of a power-down, which separates restarting the timer from letting it run on. The third sends a run strobe while powering down, which shows whether the converters drop out before the new wake-up begins. The last pattern applies over-temperature pulses, first after a run command and then after a standby command, to show that automatic recovery follows the last software request and not the thermal input alone.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    PS_STANDBY  = 2'd0,
    PS_WAKING   = 2'd1,
    PS_ACTIVE   = 2'd2,
    PS_SHUTTING = 2'd3
  } pwrState_t;

  // strobes from control to the interval timer
  typedef struct packed {
    logic tmrClear;
    logic tmrStep;
  } tmrCtl_t;

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer
  import pwrseq_pkg::*;
#(
  parameter int unsigned WAKE_CYC  = 1200000,
  parameter int unsigned SLEEP_CYC = 10000
) (
  input  logic    clk,
  input  logic    rstN,
  input  tmrCtl_t tmrCtl,
  input  logic    overTemp,
  output logic    wakeDone,
  output logic    sleepDone,
  output logic    thermalFlag
);

  localparam int unsigned MAX_CYC = (WAKE_CYC > SLEEP_CYC) ? WAKE_CYC : SLEEP_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (tmrCtl.tmrClear) begin
      cnt <= '0;
    end else if (tmrCtl.tmrStep) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign wakeDone  = (cnt == CNT_W'(WAKE_CYC - 1));
  assign sleepDone = (cnt == CNT_W'(SLEEP_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) thermalFlag <= 1'b0;
    else       thermalFlag <= overTemp;
  end

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdStrobe,
  input  logic           cmdStandby,
  input  logic [NCH-1:0] cmdEnable,
  input  logic           overTemp,
  input  logic           wakeDone,
  input  logic           sleepDone,
  output tmrCtl_t        tmrCtl,
  output logic           convEn,
  output logic [NCH-1:0] chanEn,
  output logic           outReady
);

  pwrState_t      state, nextState;
  logic           swOff;
  logic [NCH-1:0] enMask;
  logic           offNext, wantOn, stageOn;

  always_comb begin
    offNext   = cmdStrobe ? cmdStandby : swOff;
    wantOn    = !offNext && !overTemp;
    nextState = state;
    tmrCtl    = '0;
    case (state)
      PS_STANDBY: begin
        if (wantOn) begin
          nextState       = PS_WAKING;
          tmrCtl.tmrClear = 1'b1;
        end
      end
      PS_WAKING: begin
        if (!wantOn) begin
          nextState       = PS_SHUTTING;
          tmrCtl.tmrClear = 1'b1;
        end else if (cmdStrobe) begin
          tmrCtl.tmrClear = 1'b1;
        end else if (wakeDone) begin
          nextState = PS_ACTIVE;
        end else begin
          tmrCtl.tmrStep = 1'b1;
        end
      end
      PS_ACTIVE: begin
        if (!wantOn) begin
          nextState       = PS_SHUTTING;
          tmrCtl.tmrClear = 1'b1;
        end
      end
      PS_SHUTTING: begin
        if (wantOn) begin
          nextState       = PS_WAKING;
          tmrCtl.tmrClear = 1'b1;
        end else if (cmdStrobe) begin
          tmrCtl.tmrClear = 1'b1;
        end else if (sleepDone) begin
          nextState = PS_STANDBY;
        end else begin
          tmrCtl.tmrStep = 1'b1;
        end
      end
      default: nextState = PS_STANDBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= PS_STANDBY;
      swOff  <= 1'b1;
      enMask <= '0;
    end else begin
      state <= nextState;
      swOff <= offNext;
      if (cmdStrobe) enMask <= cmdEnable;
    end
  end

  assign convEn   = (state != PS_STANDBY);
  assign outReady = (state == PS_ACTIVE);
  assign stageOn  = (state == PS_WAKING) || (state == PS_ACTIVE);

  for (genvar g = 0; g < NCH; g++) begin : gChan
    assign chanEn[g] = enMask[g] & stageOn;
  end

endmodule

// File: rtl/audio_pwr_seq.sv
module audio_pwr_seq
  import pwrseq_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned WAKE_US  = 12000,
  parameter int unsigned SLEEP_US = 100,
  parameter int unsigned NCH      = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdStrobe,
  input  logic           cmdStandby,
  input  logic [NCH-1:0] cmdEnable,
  input  logic           overTemp,
  output logic           convEn,
  output logic [NCH-1:0] chanEn,
  output logic           outReady,
  output logic           thermalFlag
);

  localparam longint unsigned WAKE_L  = (64'(CLK_HZ) * 64'(WAKE_US)) / 64'd1000000;
  localparam longint unsigned SLEEP_L = (64'(CLK_HZ) * 64'(SLEEP_US)) / 64'd1000000;
  localparam int unsigned WAKE_CYC  = 32'(WAKE_L);
  localparam int unsigned SLEEP_CYC = 32'(SLEEP_L);

  tmrCtl_t tmrCtl;
  logic    wakeDone, sleepDone;

  pwrseq_ctrl #(.NCH(NCH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdStrobe(cmdStrobe), .cmdStandby(cmdStandby), .cmdEnable(cmdEnable),
    .overTemp(overTemp), .wakeDone(wakeDone), .sleepDone(sleepDone),
    .tmrCtl(tmrCtl), .convEn(convEn), .chanEn(chanEn), .outReady(outReady)
  );

  pwrseq_timer #(.WAKE_CYC(WAKE_CYC), .SLEEP_CYC(SLEEP_CYC)) uTimer (
    .clk(clk), .rstN(rstN), .tmrCtl(tmrCtl), .overTemp(overTemp),
    .wakeDone(wakeDone), .sleepDone(sleepDone), .thermalFlag(thermalFlag)
  );

endmodule

// File: rtl/audio_pwr_seq_chk.sv
module audio_pwr_seq_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rstN,
  input logic           cmdStrobe,
  input logic           cmdStandby,
  input logic           overTemp,
  input logic           convEn,
  input logic [NCH-1:0] chanEn,
  input logic           outReady,
  input logic           thermalFlag
);

  AST_READY_NEEDS_CONV: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> convEn); // R4

  AST_STAGES_OFF_UNPOWERED: assert property (@(posedge clk) disable iff (!rstN)
    !convEn |-> (chanEn == '0)); // R6

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    overTemp |=> thermalFlag); // R10

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !overTemp |=> !thermalFlag); // R10

  AST_HOT_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    overTemp |=> !outReady); // R9

  AST_STANDBY_CMD_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && cmdStandby) |=> (!outReady && chanEn == '0)); // R5

  AST_WAKE_POWERS: assert property (@(posedge clk) disable iff (!rstN)
    (!convEn && cmdStrobe && !cmdStandby && !overTemp) |=> convEn); // R2

endmodule

bind audio_pwr_seq audio_pwr_seq_chk #(.NCH(NCH)) uChk (
  .clk(clk), .rstN(rstN), .cmdStrobe(cmdStrobe), .cmdStandby(cmdStandby),
  .overTemp(overTemp), .convEn(convEn), .chanEn(chanEn),
  .outReady(outReady), .thermalFlag(thermalFlag)
);

// File: tb/sim_audio_pwr_seq.sv
module sim_audio_pwr_seq;

  localparam int unsigned CLK_HZ   = 100_000;
  localparam int unsigned WAKE_US  = 12000;
  localparam int unsigned SLEEP_US = 100;
  localparam int NCH   = 2;
  localparam int WAKE  = 1200; // 100 kHz * 12 ms
  localparam int SLEEP = 10;   // 100 kHz * 100 us

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStrobe = 1'b0;
  logic cmdStandby = 1'b1;
  logic [NCH-1:0] cmdEnable = '0;
  logic overTemp = 1'b0;
  logic convEn, outReady, thermalFlag;
  logic [NCH-1:0] chanEn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  audio_pwr_seq #(.CLK_HZ(CLK_HZ), .WAKE_US(WAKE_US), .SLEEP_US(SLEEP_US), .NCH(NCH)) u0 (
    .clk(clk), .rstN(rstN), .cmdStrobe(cmdStrobe), .cmdStandby(cmdStandby),
    .cmdEnable(cmdEnable), .overTemp(overTemp), .convEn(convEn), .chanEn(chanEn),
    .outReady(outReady), .thermalFlag(thermalFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: mode 0 off, 1 powering up, 2 on, 3 powering down
  int mMode = 0;
  int mLeft = 0;
  bit mOff  = 1;
  int mMask = 0;
  bit mFlag = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mLeft = 0; mOff = 1; mMask = 0; mFlag = 0;
    end else begin
      bit off, run;
      off = cmdStrobe ? cmdStandby : mOff;
      run = !off && !overTemp;
      if (mMode == 0) begin
        if (run) begin mMode = 1; mLeft = WAKE; end
      end else if (mMode == 1) begin
        if (!run) begin mMode = 3; mLeft = SLEEP; end
        else if (cmdStrobe) mLeft = WAKE;
        else begin mLeft--; if (mLeft == 0) mMode = 2; end
      end else if (mMode == 2) begin
        if (!run) begin mMode = 3; mLeft = SLEEP; end
      end else begin
        if (run) begin mMode = 1; mLeft = WAKE; end
        else if (cmdStrobe) mLeft = SLEEP;
        else begin mLeft--; if (mLeft == 0) mMode = 0; end
      end
      mOff = off;
      if (cmdStrobe) mMask = int'(cmdEnable);
      mFlag = overTemp;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      int expChan;
      expChan = (mMode == 1 || mMode == 2) ? mMask : 0;
      check(convEn == (mMode != 0), "R2/R5 convEn", int'(convEn), int'(mMode != 0));
      check(outReady == (mMode == 2), "R3 outReady", int'(outReady), int'(mMode == 2));
      check(int'(chanEn) == expChan, "R6 chanEn", int'(chanEn), expChan);
      check(thermalFlag == mFlag, "R10 thermalFlag", int'(thermalFlag), int'(mFlag));
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input bit stby, input logic [NCH-1:0] en);
    cmdStrobe = 1'b1; cmdStandby = stby; cmdEnable = en;
    @(negedge clk);
    cmdStrobe = 1'b0;
  endtask

  initial begin
    cycles(4);
    check(convEn == 0 && outReady == 0 && chanEn == 0 && thermalFlag == 0, "R1 reset",
          int'({convEn, outReady, chanEn, thermalFlag}), 0);
    rstN = 1'b1;
    cycles(2);

    // clean wake
    send(1'b0, 2'b01);
    check(convEn == 1, "R2 converters on", int'(convEn), 1);
    check(chanEn == 2'b01, "R6 left stage", int'(chanEn), 1);
    cycles(WAKE - 1);
    check(outReady == 0, "R3 not ready early", int'(outReady), 0);
    cycles(1);
    check(outReady == 1, "R3 ready on time", int'(outReady), 1);

    // repeat run command while on
    send(1'b0, 2'b11);
    check(outReady == 1 && chanEn == 2'b11, "R12 run repeat keeps power", int'({outReady, chanEn}), 7);

    // power down
    send(1'b1, 2'b11);
    check(outReady == 0 && chanEn == 0 && convEn == 1, "R5 down start", int'({convEn, outReady, chanEn}), 4);
    cycles(SLEEP - 1);
    check(convEn == 1, "R5 still powered", int'(convEn), 1);
    cycles(1);
    check(convEn == 0, "R5 converters off", int'(convEn), 0);

    // restart during wake
    send(1'b0, 2'b10);
    cycles(300);
    send(1'b0, 2'b10);
    cycles(WAKE - 1);
    check(outReady == 0, "R7 wake restarted", int'(outReady), 0);
    cycles(1);
    check(outReady == 1, "R7 ready after restart", int'(outReady), 1);

    // restart during power-down
    send(1'b1, 2'b00);
    cycles(4);
    send(1'b1, 2'b00);
    cycles(SLEEP - 1);
    check(convEn == 1, "R7 power-down restarted", int'(convEn), 1);
    cycles(1);
    check(convEn == 0, "R7 off after restart", int'(convEn), 0);

    // run during power-down
    send(1'b0, 2'b11);
    cycles(WAKE + 2);
    send(1'b1, 2'b11);
    cycles(3);
    send(1'b0, 2'b11);
    check(convEn == 1 && chanEn == 2'b11, "R8 rewake", int'({convEn, chanEn}), 7);
    cycles(WAKE - 1);
    check(outReady == 0, "R8 not ready early", int'(outReady), 0);
    cycles(1);
    check(outReady == 1, "R8 ready", int'(outReady), 1);

    // thermal event
    overTemp = 1'b1;
    cycles(1);
    check(outReady == 0 && thermalFlag == 1, "R9 forced down", int'({outReady, thermalFlag}), 1);
    send(1'b0, 2'b11);
    cycles(SLEEP + 5);
    check(convEn == 0, "R9 run ignored while hot", int'(convEn), 0);
    overTemp = 1'b0;
    cycles(1);
    check(thermalFlag == 0 && convEn == 1, "R11 auto wake, R10 flag clear", int'({thermalFlag, convEn}), 1);
    cycles(WAKE);
    check(outReady == 1, "R11 ready after recovery", int'(outReady), 1);

    // thermal pulse after standby command
    send(1'b1, 2'b00);
    cycles(SLEEP + 2);
    overTemp = 1'b1;
    cycles(5);
    overTemp = 1'b0;
    cycles(20);
    check(convEn == 0, "R11 stays standby", int'(convEn), 0);

    // repeated standby command
    send(1'b1, 2'b11);
    cycles(3);
    check(convEn == 0 && chanEn == 0, "R12 standby repeat", int'({convEn, chanEn}), 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule